// File: doc/BRIEF.md
# Multi-Digit Decimal Adder/Subtractor

This block adds or subtracts two packed binary-coded decimal operands of a parameterised number of digits in a single combinational path. Each decimal digit is handled by its own cell. The cell forms a plain binary sum of its two digits and an incoming carry. When that sum leaves the decimal range, the cell adds six to it, and the same condition becomes the carry into the next cell up.

For subtraction, every digit of the second operand first passes through a complement stage that replaces d with 9-d. A one is then fed into the lowest cell. The result is the ten's-complement difference. A final carry of one marks a difference that is zero or positive. A final carry of zero marks the complement of a negative difference. The block expects legal decimal digits on its inputs and does not check for illegal codes.

Top module: `bcd_addsub`

## Requirements
- R1: Digit i of each operand and of the result occupies bits 4i+3 down to 4i, with digit 0 the least significant. Each digit value is the plain binary code 0 to 9.
- R2: Each cell's output digit equals (a + b' + c) mod 10, where b' is the effective second digit and c is the cell's incoming carry. Its outgoing carry is 1 exactly when a + b' + c is 10 or more.
- R3: A cell applies the plus-six correction exactly when its 5-bit raw binary sum exceeds 9. That correction signal is the cell's outgoing carry.
- R4: With legal input digits, every result digit is a legal decimal digit (at most 9).
- R5: The largest raw sum a cell can see is 9 + 9 + 1. It yields digit 9 with carry 1.
- R6: With `sub` = 1, each digit of `opb` is replaced by 9 minus that digit before it is added.
- R7: With `sub` = 0, `res` is (A + B + `cin`) mod 10^D and `cout` is 1 exactly when A + B + `cin` is at least 10^D.
- R8: With `sub` = 1, the lowest carry is forced to 1 and `cin` has no effect. `res` is (A - B) mod 10^D and `cout` is 1 exactly when A >= B.
- R9: Carries ripple from digit 0 up to digit D-1. An all-nines operand plus one gives an all-zero result with `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4*DIGITS | First operand (minuend when subtracting), packed decimal |
| opb | input | 4*DIGITS | Second operand (subtrahend when subtracting), packed decimal |
| sub | input | 1 | 1 selects subtraction, 0 selects addition |
| cin | input | 1 | Carry into the lowest digit in add mode |
| res | output | 4*DIGITS | Packed decimal result |
| cout | output | 1 | Carry out of the highest digit |

## Verification
A single cell is swept over all one hundred legal digit pairs, with both carry values, in both modes. The upper operand digits are held at zero so that the carry shows up directly as the next result digit. This sweep separates a wrong correction threshold (sums of exactly 9, 10 and 16 to 19) from a wrong complement table. Fixed corner operands test the longest ripple (all nines plus one), equal operands and subtraction that borrows. Random multi-digit pairs in both modes are compared with integer arithmetic. In subtract mode each pair is driven with both `cin` values, which shows whether `cin` leaks into the result.

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] opa,
  input  logic [4*DIGITS-1:0] opb,
  input  logic                sub,
  input  logic                cin,
  output logic [4*DIGITS-1:0] res,
  output logic                cout
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0] carry;

  assign carry[0] = sub | cin;
  assign cout     = carry[DIGITS];

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] da, db, dbx, dsum;
    logic [4:0] raw;
    logic       fix;

    assign da   = opa[4*i +: 4];
    assign db   = opb[4*i +: 4];
    assign dbx  = sub ? (4'd9 - db) : db;
    assign raw  = {1'b0, da} + {1'b0, dbx} + {4'd0, carry[i]};
    assign fix  = raw[4] | (raw[3] & raw[2]) | (raw[3] & raw[1]);
    assign dsum = raw[3:0] + (fix ? 4'd6 : 4'd0);
    assign res[4*i +: 4] = dsum;
    assign carry[i+1]    = fix;

    always_comb begin
      if (da <= 4'd9 && db <= 4'd9) begin
        a_r4_digit_legal: assert (dsum <= 4'd9)
          else $error("R4 digit %0d illegal", i);
        a_r3_fix_threshold: assert (fix == (raw > 5'd9))
          else $error("R3 correction mismatch at digit %0d", i);
        a_r2_weighted_sum: assert ({1'b0, dsum} + (carry[i+1] ? 5'd10 : 5'd0) == raw)
          else $error("R2 digit %0d weight mismatch", i);
        if (sub) begin
          a_r6_nines: assert ({1'b0, dbx} + {1'b0, db} == 5'd9)
            else $error("R6 complement wrong at digit %0d", i);
        end
      end
    end
  end

  always_comb begin
    if (sub) begin
      a_r8_forced_one: assert (carry[0] == 1'b1)
        else $error("R8 lowest carry not forced");
    end
  end

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/tb_bcd_addsub.sv
module tb_bcd_addsub;
  localparam int D = 4;
  localparam int W = 4 * D;
  localparam int MOD = 10000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] opa, opb, res;
  logic sub, cin, cout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bcd_addsub #(.DIGITS(D)) dut (
    .opa(opa), .opb(opb), .sub(sub), .cin(cin), .res(res), .cout(cout)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    r = '0;
    t = v;
    for (int k = 0; k < D; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic apply(input int a, input int b, input bit s, input bit c, input string tag);
    int t;
    logic [W-1:0] exp_res;
    logic exp_c;
    if (s) t = a + (MOD - 1 - b) + 1;
    else   t = a + b + int'(c);
    exp_res = to_bcd(t % MOD);
    exp_c   = (t >= MOD);
    @(posedge clk);
    opa = to_bcd(a);
    opb = to_bcd(b);
    sub = s;
    cin = c;
    @(negedge clk);
    n_cmp++;
    if (res !== exp_res || cout !== exp_c) begin
      n_bad++;
      $display("FAIL %s: a=%0d b=%0d sub=%0b cin=%0b got res=%h cout=%0b exp res=%h cout=%0b",
               tag, a, b, s, c, res, cout, exp_res, exp_c);
    end
  endtask

  initial begin
    opa = '0; opb = '0; sub = 1'b0; cin = 1'b0;
    apply(0, 0, 0, 0, "R1 zero operands");
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          apply(a, b, 1'b0, c[0], "R2 R3 R4 single cell add");
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          apply(a, b, 1'b1, c[0], "R6 R8 single cell subtract");
    apply(9, 9, 0, 1, "R5 max raw sum");
    apply(9999, 9999, 0, 1, "R5 max all digits");
    apply(9999, 0, 0, 1, "R9 full ripple");
    apply(9990, 9, 0, 1, "R9 ripple from digit 0");
    apply(1234, 1234, 1, 0, "R8 equal operands");
    apply(0, 1, 1, 0, "R8 negative difference");
    apply(1000, 1, 1, 1, "R8 borrow chain cin ignored");
    apply(5000, 5000, 0, 0, "R7 exact overflow");
    for (int k = 0; k < 300; k++) begin
      int a, b;
      a = int'($urandom_range(0, MOD - 1));
      b = int'($urandom_range(0, MOD - 1));
      apply(a, b, 1'b0, k[0], "R7 random add");
      apply(a, b, 1'b1, 1'b0, "R8 random subtract cin0");
      apply(a, b, 1'b1, 1'b1, "R8 random subtract cin1");
    end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule